// File: doc/BRIEF.md
# Interleaved Translation Home Array

This block holds the on-chip part of a distributed address translation table that sits beside the directory controller of a multi-core chip. There is one slice per core. Every virtual page number has exactly one home slice, chosen by its low-order bits. When a private TLB misses, the request goes to that single home slice and to no other. No other TLB is snooped. The home slice answers with a hit and the physical page number, or with a miss. Either way the answer carries the requesting core's identity, so the return path can route it.

When the home slice misses, the operating-system walk supplies the translation as a fill. The block writes the fill into the home slice. In the next cycle it also presents the fill on a TLB delivery port, tagged with the core that asked for it. Each slice is set-associative. Because the home bits are implied by the slice position, the tag keeps only the page-number bits above the home and set fields. A fill for a page that is already present rewrites that entry. A fill for a new page takes a free way if the set has one, and otherwise the way under the set's round-robin pointer.

The page walk, the interconnect and the TLBs are outside this block. A lookup and a fill may arrive in the same cycle.

Top module: `xlt_home_array`

## Requirements
- R1: After reset, neither output valid is asserted and every slice is empty, so the first lookup of any page reports a miss.
- R2: The home slice of a page is `vpn[HOME_W-1:0]`, with HOME_W = log2(NUM_CORES). Only that slice serves a lookup of the page, and `rsp_home_o` reports the serving slice.
- R3: Each lookup produces exactly one response, in the cycle after the request is sampled. The response echoes the requester core and the page number.
- R4: A lookup of an installed page returns hit = 1 and the installed physical page. A lookup of an absent page returns hit = 0 and a physical page of 0.
- R5: A fill appears on the TLB delivery port in the cycle after it is sampled. It carries the same core, page number and physical page.
- R6: A fill is installed only in its home slice. A page that differs only in the home bits still misses afterwards.
- R7: A fill for a page already present rewrites its physical page in place and takes no additional way.
- R8: The set index is `vpn[HOME_W +: SET_W]`, with SET_W = log2(ENTRIES/WAYS). A fill for a new page takes the lowest-numbered free way. In a full set it evicts the way under a per-set round-robin pointer. That pointer starts at way 0 and advances by one after each eviction.
- R9: Each slice holds ENTRIES (64) distinct translations at the same time, spread over all sets and ways.
- R10: A lookup sampled in the same cycle as a fill sees the contents from before that fill. A lookup sampled one cycle later sees the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Lookup request from a missing TLB |
| req_core_i | input | CORE_W | Requesting core |
| req_vpn_i | input | VPN_W | Virtual page number to translate |
| fill_valid_i | input | 1 | Translation supplied by the OS walk |
| fill_core_i | input | CORE_W | Core whose TLB receives the fill |
| fill_vpn_i | input | VPN_W | Filled virtual page number |
| fill_ppn_i | input | PPN_W | Filled physical page number |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Translation was found |
| rsp_core_o | output | CORE_W | Requester of this response |
| rsp_vpn_o | output | VPN_W | Page number that was looked up |
| rsp_ppn_o | output | PPN_W | Physical page on a hit, zero on a miss |
| rsp_home_o | output | CORE_W | Slice that produced the response |
| tlb_valid_o | output | 1 | Fill delivery to the requester's TLB |
| tlb_core_o | output | CORE_W | Destination core of the delivery |
| tlb_vpn_o | output | VPN_W | Delivered virtual page number |
| tlb_ppn_o | output | PPN_W | Delivered physical page number |

## Verification
The assertions check four things on every cycle. At most one slice answers. Each slice sees only lookups and fills whose low page bits equal its own index. A response follows every request and a TLB delivery follows every fill, each one cycle later with the fields echoed. No set ever holds two valid copies of the same tag. What only the bench scenarios can show is content-dependent. That covers the correct physical page on a hit after an in-place update, the exact victim order under free-way-first and round-robin eviction, full 64-entry occupancy of one slice, and the pre-fill view seen by a lookup that coincides with a fill.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  // What a fill does to the addressed set.
  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_FREE   = 2'd2,
    FILL_EVICT  = 2'd3
  } fill_kind_e;

endpackage

// File: rtl/xlt_home_sel.sv
module xlt_home_sel #(
  parameter int NUM_SLICES = 4,
  parameter int VPN_W      = 20
) (
  input  logic [VPN_W-1:0]      vpn_i,
  output logic [NUM_SLICES-1:0] sel_o
);
  localparam int HOME_W = $clog2(NUM_SLICES);
  localparam logic [VPN_W-1:0] HOME_MASK = VPN_W'(NUM_SLICES - 1);

  logic [HOME_W-1:0] home;

  // Home slice from the low page bits: a mask, then a shift into one-hot form.
  always_comb begin
    home  = HOME_W'(vpn_i & HOME_MASK);
    sel_o = NUM_SLICES'(1) << home;
  end

  initial begin
    AST_POW2_SLICES: assert ((1 << HOME_W) == NUM_SLICES && NUM_SLICES >= 2)
      else $error("slice count must be a power of two"); // R2
  end

endmodule

// File: rtl/xlt_victim.sv
module xlt_victim
  import xlt_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0]         valid_i,
  input  logic [WAYS-1:0]         match_i,
  input  logic [$clog2(WAYS)-1:0] rr_i,
  output logic [$clog2(WAYS)-1:0] way_o,
  output fill_kind_e              kind_o
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_i[w]) hit_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) free_way = WAY_W'(w);
    end
    if (|match_i) begin
      way_o  = hit_way;
      kind_o = FILL_UPDATE;
    end else if (!(&valid_i)) begin
      way_o  = free_way;
      kind_o = FILL_FREE;
    end else begin
      way_o  = rr_i;
      kind_o = FILL_EVICT;
    end
  end

endmodule

// File: rtl/xlt_slice.sv
module xlt_slice
  import xlt_pkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int SLICE_ID   = 0,
  parameter int VPN_W      = 20,
  parameter int PPN_W      = 16,
  parameter int CORE_W     = 2,
  parameter int ENTRIES    = 64,
  parameter int WAYS       = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              lk_valid_i,
  input  logic [CORE_W-1:0] lk_core_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic              fl_valid_i,
  input  logic [VPN_W-1:0]  fl_vpn_i,
  input  logic [PPN_W-1:0]  fl_ppn_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [CORE_W-1:0] rsp_core_o,
  output logic [VPN_W-1:0]  rsp_vpn_o,
  output logic [PPN_W-1:0]  rsp_ppn_o
);
  localparam int HOME_W = $clog2(NUM_SLICES);
  localparam int SETS   = ENTRIES / WAYS;
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int ENT_W  = SET_W + WAY_W;
  localparam int TAG_W  = VPN_W - HOME_W - SET_W;

  // Tag and valid state live in flops so lookup and fill can both compare in one cycle.
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAY_W-1:0] rr_q  [SETS];
  // Physical pages live in a plain synchronous-read array suited to block RAM.
  logic [PPN_W-1:0] ppn_mem [ENTRIES];

  logic [SET_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [WAYS-1:0]  lk_match, fl_match;
  logic [WAY_W-1:0] lk_way, fl_way;
  fill_kind_e       fl_kind;

  logic [PPN_W-1:0]  rd_q;
  logic              rsp_valid_q, rsp_hit_q;
  logic [CORE_W-1:0] rsp_core_q;
  logic [VPN_W-1:0]  rsp_vpn_q;

  always_comb begin
    lk_set = lk_vpn_i[HOME_W +: SET_W];
    lk_tag = lk_vpn_i[VPN_W-1 -: TAG_W];
    fl_set = fl_vpn_i[HOME_W +: SET_W];
    fl_tag = fl_vpn_i[VPN_W-1 -: TAG_W];
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      fl_match[w] = vld_q[fl_set][w] && (tag_q[fl_set][w] == fl_tag);
      if (lk_match[w]) lk_way = WAY_W'(w);
    end
  end

  xlt_victim #(.WAYS(WAYS)) u_victim (
    .valid_i (vld_q[fl_set]),
    .match_i (fl_match),
    .rr_i    (rr_q[fl_set]),
    .way_o   (fl_way),
    .kind_o  (fl_kind)
  );

  // Physical page array: write on fill, read-first on lookup.
  always_ff @(posedge clk_i) begin
    if (fl_valid_i) ppn_mem[ENT_W'({fl_set, fl_way})] <= fl_ppn_i;
    rd_q <= ppn_mem[ENT_W'({lk_set, lk_way})];
  end

  always_ff @(posedge clk_i) begin
    if (fl_valid_i) tag_q[fl_set][fl_way] <= fl_tag;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (fl_valid_i) begin
      vld_q[fl_set][fl_way] <= 1'b1;
      if (fl_kind == FILL_EVICT) rr_q[fl_set] <= rr_q[fl_set] + WAY_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= lk_valid_i;
      rsp_hit_q   <= lk_valid_i && (|lk_match);
    end
    if (lk_valid_i) begin
      rsp_core_q <= lk_core_i;
      rsp_vpn_q  <= lk_vpn_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_core_o  = rsp_core_q;
  assign rsp_vpn_o   = rsp_vpn_q;
  assign rsp_ppn_o   = rsp_hit_q ? rd_q : '0;

  AST_LOOKUP_AT_HOME: assert property (@(posedge clk_i) disable iff (rst_i) lk_valid_i |-> (lk_vpn_i[HOME_W-1:0] == HOME_W'(SLICE_ID))) else $error("lookup routed to wrong slice"); // R2
  AST_FILL_AT_HOME: assert property (@(posedge clk_i) disable iff (rst_i) fl_valid_i |-> (fl_vpn_i[HOME_W-1:0] == HOME_W'(SLICE_ID))) else $error("fill routed to wrong slice"); // R6
  AST_NO_DUP_TAG: assert property (@(posedge clk_i) disable iff (rst_i) lk_valid_i |-> ($countones(lk_match) <= 1)) else $error("duplicate tag in set"); // R7
  AST_MISS_ZERO_PPN: assert property (@(posedge clk_i) disable iff (rst_i) (rsp_valid_o && !rsp_hit_o) |-> (rsp_ppn_o == '0)) else $error("miss carries a page"); // R4

  initial begin
    AST_GEOMETRY: assert (SETS * WAYS == ENTRIES && (1 << SET_W) == SETS && (1 << WAY_W) == WAYS && TAG_W > 0)
      else $error("slice geometry must be powers of two"); // R9
  end

endmodule

// File: rtl/xlt_home_array.sv
module xlt_home_array #(
  parameter int NUM_CORES = 4,
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 16,
  parameter int ENTRIES   = 64,
  parameter int WAYS      = 4,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_valid_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  input  logic              fill_valid_i,
  input  logic [CORE_W-1:0] fill_core_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [CORE_W-1:0] rsp_core_o,
  output logic [VPN_W-1:0]  rsp_vpn_o,
  output logic [PPN_W-1:0]  rsp_ppn_o,
  output logic [CORE_W-1:0] rsp_home_o,
  output logic              tlb_valid_o,
  output logic [CORE_W-1:0] tlb_core_o,
  output logic [VPN_W-1:0]  tlb_vpn_o,
  output logic [PPN_W-1:0]  tlb_ppn_o
);
  localparam int NUM_SLICES = NUM_CORES;

  logic [NUM_SLICES-1:0] req_sel, fill_sel;
  logic [NUM_SLICES-1:0] s_valid, s_hit;
  logic [CORE_W-1:0]     s_core [NUM_SLICES];
  logic [VPN_W-1:0]      s_vpn  [NUM_SLICES];
  logic [PPN_W-1:0]      s_ppn  [NUM_SLICES];

  xlt_home_sel #(.NUM_SLICES(NUM_SLICES), .VPN_W(VPN_W)) u_req_home (
    .vpn_i (req_vpn_i),
    .sel_o (req_sel)
  );

  xlt_home_sel #(.NUM_SLICES(NUM_SLICES), .VPN_W(VPN_W)) u_fill_home (
    .vpn_i (fill_vpn_i),
    .sel_o (fill_sel)
  );

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    xlt_slice #(
      .NUM_SLICES (NUM_SLICES),
      .SLICE_ID   (s),
      .VPN_W      (VPN_W),
      .PPN_W      (PPN_W),
      .CORE_W     (CORE_W),
      .ENTRIES    (ENTRIES),
      .WAYS       (WAYS)
    ) u_slice (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .lk_valid_i  (req_valid_i && req_sel[s]),
      .lk_core_i   (req_core_i),
      .lk_vpn_i    (req_vpn_i),
      .fl_valid_i  (fill_valid_i && fill_sel[s]),
      .fl_vpn_i    (fill_vpn_i),
      .fl_ppn_i    (fill_ppn_i),
      .rsp_valid_o (s_valid[s]),
      .rsp_hit_o   (s_hit[s]),
      .rsp_core_o  (s_core[s]),
      .rsp_vpn_o   (s_vpn[s]),
      .rsp_ppn_o   (s_ppn[s])
    );
  end

  // Merge the slice responses; at most one slice answers in any cycle.
  always_comb begin
    rsp_valid_o = 1'b0;
    rsp_hit_o   = 1'b0;
    rsp_core_o  = '0;
    rsp_vpn_o   = '0;
    rsp_ppn_o   = '0;
    rsp_home_o  = '0;
    for (int s = 0; s < NUM_SLICES; s++) begin
      if (s_valid[s]) begin
        rsp_valid_o = 1'b1;
        rsp_hit_o   = s_hit[s];
        rsp_core_o  = s_core[s];
        rsp_vpn_o   = s_vpn[s];
        rsp_ppn_o   = s_ppn[s];
        rsp_home_o  = CORE_W'(s);
      end
    end
  end

  // Deliver every fill to the requester's TLB one cycle later.
  always_ff @(posedge clk_i) begin
    if (rst_i) tlb_valid_o <= 1'b0;
    else       tlb_valid_o <= fill_valid_i;
    if (fill_valid_i) begin
      tlb_core_o <= fill_core_i;
      tlb_vpn_o  <= fill_vpn_i;
      tlb_ppn_o  <= fill_ppn_i;
    end
  end

  AST_ONE_SLICE_ANSWERS: assert property (@(posedge clk_i) disable iff (rst_i) $onehot0(s_valid)) else $error("several slices answered"); // R2
  AST_HOME_MATCHES_VPN: assert property (@(posedge clk_i) disable iff (rst_i) rsp_valid_o |-> (rsp_home_o == rsp_vpn_o[CORE_W-1:0])) else $error("response from non-home slice"); // R2
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (rst_i) req_valid_i |=> (rsp_valid_o && rsp_core_o == $past(req_core_i) && rsp_vpn_o == $past(req_vpn_i))) else $error("response missing or wrong"); // R3
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (rst_i) !req_valid_i |=> !rsp_valid_o) else $error("spurious response"); // R3
  AST_TLB_AFTER_FILL: assert property (@(posedge clk_i) disable iff (rst_i) fill_valid_i |=> (tlb_valid_o && tlb_core_o == $past(fill_core_i) && tlb_vpn_o == $past(fill_vpn_i) && tlb_ppn_o == $past(fill_ppn_i))) else $error("fill not delivered"); // R5
  AST_NO_TLB_WITHOUT_FILL: assert property (@(posedge clk_i) disable iff (rst_i) !fill_valid_i |=> !tlb_valid_o) else $error("spurious delivery"); // R5

endmodule

// File: tb/tb_xlt_home_array.sv
module tb_xlt_home_array;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CORES  = 4;
  localparam int VPN_W      = 20;
  localparam int PPN_W      = 16;
  localparam int CORE_W     = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              req_valid = 1'b0, fill_valid = 1'b0;
  logic [CORE_W-1:0] req_core = '0, fill_core = '0;
  logic [VPN_W-1:0]  req_vpn = '0, fill_vpn = '0;
  logic [PPN_W-1:0]  fill_ppn = '0;
  logic              rsp_valid, rsp_hit, tlb_valid;
  logic [CORE_W-1:0] rsp_core, rsp_home, tlb_core;
  logic [VPN_W-1:0]  rsp_vpn, tlb_vpn;
  logic [PPN_W-1:0]  rsp_ppn, tlb_ppn;

  xlt_home_array #(.NUM_CORES(NUM_CORES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(64), .WAYS(4)) dut (
    .clk_i(clk), .rst_i(rst),
    .req_valid_i(req_valid), .req_core_i(req_core), .req_vpn_i(req_vpn),
    .fill_valid_i(fill_valid), .fill_core_i(fill_core), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_core_o(rsp_core), .rsp_vpn_o(rsp_vpn),
    .rsp_ppn_o(rsp_ppn), .rsp_home_o(rsp_home),
    .tlb_valid_o(tlb_valid), .tlb_core_o(tlb_core), .tlb_vpn_o(tlb_vpn), .tlb_ppn_o(tlb_ppn)
  );

  typedef struct {
    logic              hit;
    logic [PPN_W-1:0]  ppn;
    logic [CORE_W-1:0] core;
    logic [VPN_W-1:0]  vpn;
    string             rq;
  } exp_t;

  exp_t rsp_q[$];
  exp_t tlb_q[$];
  logic [PPN_W-1:0] model [logic [VPN_W-1:0]];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  function automatic logic [VPN_W-1:0] mk(int tag, int set, int home);
    return VPN_W'((tag << 6) | (set << 2) | home);
  endfunction

  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; expectations are taken before the fill lands (R10).
  task automatic drive(bit rv, int rc, logic [VPN_W-1:0] rvpn,
                       bit fv, int fc, logic [VPN_W-1:0] fvpn, logic [PPN_W-1:0] fppn, string rq);
    exp_t e;
    if (rv) begin
      e.hit  = model.exists(rvpn);
      e.ppn  = e.hit ? model[rvpn] : '0;
      e.core = CORE_W'(rc);
      e.vpn  = rvpn;
      e.rq   = rq;
      rsp_q.push_back(e);
    end
    if (fv) begin
      e.hit  = 1'b1;
      e.ppn  = fppn;
      e.core = CORE_W'(fc);
      e.vpn  = fvpn;
      e.rq   = rq;
      tlb_q.push_back(e);
      model[fvpn] = fppn;
    end
    @(posedge clk);
    #1;
    req_valid  = rv;
    req_core   = CORE_W'(rc);
    req_vpn    = rvpn;
    fill_valid = fv;
    fill_core  = CORE_W'(fc);
    fill_vpn   = fvpn;
    fill_ppn   = fppn;
  endtask

  task automatic lookup(int c, logic [VPN_W-1:0] v, string rq);
    drive(1'b1, c, v, 1'b0, 0, '0, '0, rq);
  endtask

  task automatic fill(int c, logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, string rq);
    drive(1'b0, 0, '0, 1'b1, c, v, p, rq);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, '0, 1'b0, 0, '0, '0, "");
  endtask

  // Monitor: pop and compare whenever the design presents a result.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_valid) begin
        if (rsp_q.size() == 0) begin
          check(1'b0, "R3", "response without request", rsp_vpn, 0);
        end else begin
          exp_t e;
          e = rsp_q.pop_front();
          check(rsp_hit == e.hit, e.rq, "hit", rsp_hit, e.hit);
          check(rsp_ppn == e.ppn, e.rq, "ppn", rsp_ppn, e.ppn);
          check(rsp_core == e.core, "R3", "core echo", rsp_core, e.core);
          check(rsp_vpn == e.vpn, "R3", "vpn echo", rsp_vpn, e.vpn);
          check(rsp_home == e.vpn[CORE_W-1:0], "R2", "home slice", rsp_home, e.vpn[CORE_W-1:0]);
        end
      end
      if (tlb_valid) begin
        if (tlb_q.size() == 0) begin
          check(1'b0, "R5", "delivery without fill", tlb_vpn, 0);
        end else begin
          exp_t e;
          e = tlb_q.pop_front();
          check(tlb_core == e.core && tlb_vpn == e.vpn && tlb_ppn == e.ppn, "R5", "tlb delivery",
                {tlb_core, tlb_vpn, tlb_ppn}, {e.core, e.vpn, e.ppn});
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R3 watchdog expired: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: outputs idle after reset
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(tlb_valid == 1'b0, "R1", "tlb_valid after reset", tlb_valid, 0);

    // R1/R4: empty table misses
    lookup(1, mk(5, 3, 1), "R1");
    lookup(0, mk(9, 0, 2), "R1");

    // R5/R4/R3: install then hit from another core
    fill(2, mk(5, 3, 1), 16'h1234, "R5");
    lookup(3, mk(5, 3, 1), "R4");

    // R6: same upper bits, other homes miss
    lookup(0, mk(5, 3, 0), "R6");
    lookup(1, mk(5, 3, 2), "R6");
    lookup(2, mk(5, 3, 3), "R6");

    // R7: refill updates in place
    fill(1, mk(5, 3, 1), 16'h0aaa, "R7");
    lookup(1, mk(5, 3, 1), "R7");
    fill(1, mk(6, 3, 1), 16'h0006, "R7");
    fill(1, mk(7, 3, 1), 16'h0007, "R7");
    fill(1, mk(8, 3, 1), 16'h0008, "R7");
    for (int t = 5; t <= 8; t++) lookup(2, mk(t, 3, 1), "R7");

    // R8: full set evicts round-robin from way 0 (tag 5), then way 1 (tag 6)
    fill(0, mk(9, 3, 1), 16'h0009, "R8");
    model.delete(mk(5, 3, 1));
    lookup(0, mk(5, 3, 1), "R8");
    lookup(0, mk(9, 3, 1), "R8");
    lookup(0, mk(6, 3, 1), "R8");
    fill(0, mk(10, 3, 1), 16'h000a, "R8");
    model.delete(mk(6, 3, 1));
    lookup(0, mk(6, 3, 1), "R8");
    lookup(0, mk(7, 3, 1), "R8");
    lookup(0, mk(10, 3, 1), "R8");

    // R9: 64 distinct pages in slice 0, all resident at once
    for (int t = 1; t <= 4; t++)
      for (int s = 0; s < 16; s++)
        fill(s % 4, mk(t + 20, s, 0), PPN_W'(t * 256 + s), "R9");
    for (int t = 1; t <= 4; t++)
      for (int s = 0; s < 16; s++)
        lookup(t - 1, mk(t + 20, s, 0), "R9");

    // R10: coincident lookup sees pre-fill contents
    drive(1'b1, 3, mk(40, 7, 2), 1'b1, 3, mk(40, 7, 2), 16'h4007, "R10");
    lookup(3, mk(40, 7, 2), "R10");
    drive(1'b1, 2, mk(40, 7, 2), 1'b1, 2, mk(40, 7, 2), 16'h5007, "R10");
    lookup(2, mk(40, 7, 2), "R10");

    // R2: back-to-back stream across all homes
    fill(1, mk(3, 2, 3), 16'h0323, "R2");
    lookup(0, mk(3, 2, 3), "R2");
    lookup(1, mk(7, 3, 1), "R2");
    lookup(2, mk(21, 5, 0), "R2");
    lookup(3, mk(40, 7, 2), "R2");

    idle(4);
    check(rsp_q.size() == 0, "R3", "responses outstanding", rsp_q.size(), 0);
    check(tlb_q.size() == 0, "R5", "deliveries outstanding", tlb_q.size(), 0);
    finish_run();
  end

endmodule